// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address sequence inside a synchronous DRAM device model. A small mode register holds the burst length, the wrap order, the CAS latency and a write-burst option. It is loaded by a mode-register-set command. When a read or write command is sampled, the block captures the starting column and the bank. From the next cycle it presents one column per enabled clock until the programmed burst is complete. A full-page burst runs until it is stopped.

A three-state controller drives the sequence. The states are IDLE (no burst), BURST (a finite burst of 1, 2, 4 or 8 beats) and PAGE (a full-page burst). The transitions are: IDLE to BURST or PAGE on a read or write command, chosen by the burst length that applies to that command. BURST back to IDLE after the final beat. BURST or PAGE to IDLE on a burst-terminate command. Any state to BURST or PAGE on a new read or write command, which restarts the sequence at once. All other cycles keep the current state. A clock edge with clock enable low freezes every register.

Top module: `sdram_col_seq`

## Requirements
- R1: After reset, burst_act and burst_last are 0 and cas_lat reads 2. The mode register holds burst length 1, sequential order, and writes that follow the burst length.
- R2: A mode-register-set command, accepted only in IDLE, loads the following fields:
  - addr[2:0] selects the length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives full page, and any other code gives 1.
  - addr[3] selects the order: 0 is sequential, 1 is interleaved.
  - addr[6:4] selects the latency: 011 makes cas_lat 3, and any other code makes it 2.
  - addr[9] set to 1 makes writes single-beat.

  The new cas_lat is visible in the cycle after the command.
- R3: Commands are decoded from the active-low strobes {cs_n,ras_n,cas_n,we_n}:
  - 0000 is mode set.
  - 0101 is read.
  - 0100 is write.
  - 0110 is burst terminate.

  With cs_n high no command is taken. The start column is {addr[11], addr[9:0]}, and the bank is ba.
- R4: In the cycle after a read or write command edge, col_out equals the start column, bank_out equals the sampled bank, and burst_act is 1. Each following enabled edge advances the burst by one beat.
- R5: For a sequential burst of length N, beat k shows the start's upper bits unchanged, with the low log2(N) bits equal to (start + k) mod N.
- R6: For an interleaved burst of length N, beat k shows the start's upper bits unchanged, with the low log2(N) bits equal to (start XOR k).
- R7: burst_last is 1 exactly on the final beat of a finite burst, and burst_act falls in the following cycle.
- R8: A full-page burst counts (start + k) mod 2048 whatever the order bit. It never raises burst_last and runs until a burst-terminate command returns it to IDLE.
- R9: With single-beat writes selected, a write gives one beat while a read still uses the programmed length.
- R10: A read or write command during a burst abandons the current burst, and the new start column appears in the next cycle.
- R11: An edge with cke low changes no output and no state, and any command present at that edge is ignored.
- R12: A mode-register-set command while a burst is active is ignored. Neither the burst length of later commands nor cas_lat changes.
- R13: A burst-terminate command during a finite burst ends it, so burst_act is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Multiplexed address and mode key |
| col_out | output | 11 | Current burst column |
| bank_out | output | 2 | Bank of the current burst |
| burst_act | output | 1 | A burst is in progress |
| burst_last | output | 1 | Current beat is the last of a finite burst |
| cas_lat | output | 2 | Programmed CAS latency (2 or 3) |

## Verification
The assertions take for granted three things about the inputs:
- Strobes and address are stable around the rising edge.
- Reset is held long enough to clear the mode register.
- No command pattern outside the four decoded ones is relied upon.

The bench drives every input at the falling edge and only ever issues the four legal command patterns or a deselect. It sweeps each finite length and both orders over sixteen start offsets. It covers full-page wrap at column 2047, aborts, terminates, clock-enable stalls and blocked mode loads. The expected columns are computed arithmetically.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_PAGE  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic       wr_single;
        logic [2:0] lat_code;
        logic       interleave;
        logic [2:0] len_code;
    } mode_t;

    localparam logic [2:0] LEN_CODE_FULL = 3'b111;
    localparam logic [2:0] LAT_CODE_3    = 3'b011;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode (
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output logic do_mrs,
    output logic do_rd,
    output logic do_wr,
    output logic do_bst
);
    logic live;

    assign live   = cke & ~cs_n;
    assign do_mrs = live & ~ras_n & ~cas_n & ~we_n;
    assign do_rd  = live &  ras_n & ~cas_n &  we_n;
    assign do_wr  = live &  ras_n & ~cas_n & ~we_n;
    assign do_bst = live &  ras_n &  cas_n & ~we_n;

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
    import sdram_col_pkg::*;
#(
    parameter int COL_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [2:0]       len_key,
    input  logic             ilv_key,
    input  logic [2:0]       lat_key,
    input  logic             wsingle_key,
    output mode_t            mode,
    output logic [COL_W-1:0] len_mask,
    output logic             full_page,
    output logic [1:0]       cas_lat
);
    mode_t mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{wr_single: 1'b0, lat_code: 3'b010, interleave: 1'b0, len_code: 3'b000};
        end else if (load) begin
            mode_q <= '{wr_single: wsingle_key, lat_code: lat_key,
                        interleave: ilv_key, len_code: len_key};
        end
    end

    always_comb begin
        full_page = (mode_q.len_code == LEN_CODE_FULL);
        case (mode_q.len_code)
            3'b001:  len_mask = COL_W'(1);
            3'b010:  len_mask = COL_W'(3);
            3'b011:  len_mask = COL_W'(7);
            3'b111:  len_mask = '1;
            default: len_mask = '0;
        endcase
    end

    assign mode    = mode_q;
    assign cas_lat = (mode_q.lat_code == LAT_CODE_3) ? 2'd3 : 2'd2;

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
    parameter int COL_W = 11
) (
    input  logic [COL_W-1:0] start,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] mask,
    input  logic             ilv,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] step;

    always_comb begin
        step = ilv ? (start ^ beat) : (start + beat);
        col  = (start & ~mask) | (step & mask);
    end

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
    import sdram_col_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int COL_W  = 11,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] ba,
    input  logic [ADDR_W-1:0] addr,
    output logic [COL_W-1:0]  col_out,
    output logic [BANK_W-1:0] bank_out,
    output logic              burst_act,
    output logic              burst_last,
    output logic [1:0]        cas_lat
);
    localparam int AP_BIT = COL_W - 1;

    logic do_mrs, do_rd, do_wr, do_bst, new_cmd;
    logic single_wr, sel_full;
    logic [COL_W-1:0] col_in, sel_mask, len_mask;
    logic full_page;
    mode_t mode;

    seq_state_t state_q, state_d;
    logic [COL_W-1:0]  start_q, beat_q, mask_q;
    logic [BANK_W-1:0] bank_q;
    logic              ilv_q;

    logic unused_addr;
    assign unused_addr = ^{addr[ADDR_W-1:AP_BIT+2], addr[AP_BIT]};

    sdram_cmd_decode u_dec (
        .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .do_mrs(do_mrs), .do_rd(do_rd), .do_wr(do_wr), .do_bst(do_bst)
    );

    sdram_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk(clk), .rst_n(rst_n),
        .load(do_mrs && state_q == ST_IDLE),
        .len_key(addr[2:0]), .ilv_key(addr[3]), .lat_key(addr[6:4]),
        .wsingle_key(addr[9]),
        .mode(mode), .len_mask(len_mask), .full_page(full_page), .cas_lat(cas_lat)
    );

    sdram_col_gen #(.COL_W(COL_W)) u_gen (
        .start(start_q), .beat(beat_q), .mask(mask_q), .ilv(ilv_q), .col(col_out)
    );

    assign new_cmd   = do_rd | do_wr;
    assign col_in    = {addr[AP_BIT+1], addr[AP_BIT-1:0]};
    assign single_wr = do_wr & mode.wr_single;
    assign sel_full  = full_page & ~single_wr;
    assign sel_mask  = single_wr ? '0 : len_mask;

    always_comb begin
        state_d = state_q;
        if (new_cmd) begin
            state_d = sel_full ? ST_PAGE : ST_BURST;
        end else if (do_bst) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_BURST: if (beat_q == mask_q) state_d = ST_IDLE;
                ST_PAGE:  state_d = ST_PAGE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state_q <= ST_IDLE;
        else if (cke) state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            bank_q  <= '0;
            ilv_q   <= 1'b0;
        end else if (cke) begin
            if (new_cmd) begin
                start_q <= col_in;
                bank_q  <= ba;
                beat_q  <= '0;
                mask_q  <= sel_mask;
                ilv_q   <= mode.interleave & ~sel_full;
            end else if (state_q != ST_IDLE) begin
                beat_q <= beat_q + COL_W'(1);
            end
        end
    end

    assign bank_out   = bank_q;
    assign burst_act  = (state_q != ST_IDLE);
    assign burst_last = (state_q == ST_BURST) && (beat_q == mask_q);

    assert_start_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        new_cmd |=> (burst_act && col_out == $past(col_in) && bank_out == $past(ba)));

    assert_seq_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && state_q == ST_BURST && !ilv_q && !new_cmd && !do_bst && !burst_last)
        |=> ((col_out & $past(mask_q)) == (($past(col_out) + COL_W'(1)) & $past(mask_q))));

    assert_end_of_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && burst_last && !new_cmd) |=> !burst_act);

    assert_cke_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(col_out) && $stable(bank_out) && $stable(burst_act) && $stable(burst_last)));

    assert_mrs_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (do_mrs && state_q != ST_IDLE) |=> $stable(cas_lat));

endmodule

// File: tb/tb_sdram_col_seq.sv
module tb_sdram_col_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [3:0] C_NOP = 4'b0111, C_MRS = 4'b0000, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_BST = 4'b0110;

    logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
    logic cs_n, ras_n, cas_n, we_n;
    logic [1:0] ba = '0;
    logic [12:0] addr = '0;
    logic [10:0] col_out;
    logic [1:0] bank_out, cas_lat;
    logic burst_act, burst_last;
    int total = 0, bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_col_seq dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .col_out(col_out),
        .bank_out(bank_out), .burst_act(burst_act), .burst_last(burst_last),
        .cas_lat(cas_lat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [3:0] c, input logic [12:0] a, input logic [1:0] b);
        {cs_n, ras_n, cas_n, we_n} = c;
        addr = a;
        ba = b;
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
    endtask

    function automatic logic [12:0] col_addr(input logic [10:0] c);
        return {1'b0, c[10], 1'b0, c[9:0]};
    endfunction

    task automatic mrs(input logic [2:0] len, input bit ilv, input logic [2:0] lat, input bit ws);
        send(C_MRS, {3'b000, ws, 2'b00, lat, ilv, len}, 2'd0);
    endtask

    function automatic logic [10:0] exp_col(input logic [10:0] s, input int k, input int len, input bit ilv);
        logic [10:0] m;
        m = 11'(len - 1);
        return (s & ~m) | ((ilv ? (s ^ 11'(k)) : (s + 11'(k))) & m);
    endfunction

    task automatic burst(input string req, input logic [3:0] c, input int len, input bit ilv,
                         input logic [10:0] s, input logic [1:0] b);
        send(c, col_addr(s), b);
        for (int k = 0; k < len; k++) begin
            chk({req, " col"}, 32'(col_out), 32'(exp_col(s, k, len, ilv)));
            chk({req, " act"}, 32'(burst_act), 32'd1);
            chk({req, " R7 last"}, 32'(burst_last), 32'(k == len - 1));
            if (k == 0) chk({req, " R4 bank"}, 32'(bank_out), 32'(b));
            @(negedge clk);
        end
        chk({req, " R7 idle after"}, 32'(burst_act), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 act", 32'(burst_act), 32'd0);
        chk("R1 last", 32'(burst_last), 32'd0);
        chk("R1 cas_lat", 32'(cas_lat), 32'd2);
        burst("R1 default length", C_RD, 1, 0, 11'h123, 2'd1);
        // R3 deselected command ignored
        send(4'b1101, col_addr(11'h055), 2'd2);
        chk("R3 deselect", 32'(burst_act), 32'd0);
        // R2 latency field
        mrs(3'b011, 0, 3'b011, 0);
        chk("R2 cas_lat 3", 32'(cas_lat), 32'd3);
        mrs(3'b011, 0, 3'b010, 0);
        chk("R2 cas_lat 2", 32'(cas_lat), 32'd2);
        // R5 R6 sweep of lengths, orders and starts
        for (int code = 0; code < 4; code++) begin
            for (int il = 0; il < 2; il++) begin
                mrs(3'(code), il[0], 3'b010, 0);
                for (int s = 0; s < 16; s++) begin
                    burst(il[0] ? "R6 ilv" : "R5 seq", s[0] ? C_WR : C_RD, 1 << code, il[0],
                          11'h5A0 | 11'(s), 2'(s));
                end
            end
        end
        // R2 reserved length code acts as 1
        mrs(3'b101, 0, 3'b010, 0);
        burst("R2 reserved len", C_RD, 1, 0, 11'h007, 2'd0);
        // R8 full page wrap
        mrs(3'b111, 0, 3'b010, 0);
        send(C_RD, col_addr(11'd2045), 2'd3);
        for (int k = 0; k < 20; k++) begin
            chk("R8 page col", 32'(col_out), 32'((2045 + k) % 2048));
            chk("R8 page last", 32'(burst_last), 32'd0);
            chk("R8 page act", 32'(burst_act), 32'd1);
            @(negedge clk);
        end
        send(C_BST, 13'd0, 2'd0);
        chk("R8 terminate", 32'(burst_act), 32'd0);
        mrs(3'b111, 1, 3'b010, 0);
        send(C_RD, col_addr(11'd5), 2'd0);
        for (int k = 0; k < 6; k++) begin
            chk("R8 page ignores order", 32'(col_out), 32'(5 + k));
            @(negedge clk);
        end
        send(C_BST, 13'd0, 2'd0);
        chk("R8 terminate 2", 32'(burst_act), 32'd0);
        // R9 single-beat writes
        mrs(3'b010, 0, 3'b010, 1);
        burst("R9 write single", C_WR, 1, 0, 11'd6, 2'd1);
        burst("R9 read full", C_RD, 4, 0, 11'd6, 2'd1);
        // R13 terminate finite burst
        mrs(3'b011, 0, 3'b010, 0);
        send(C_RD, col_addr(11'd0), 2'd0);
        for (int k = 0; k < 3; k++) begin
            chk("R13 pre", 32'(col_out), 32'(k));
            @(negedge clk);
        end
        send(C_BST, 13'd0, 2'd0);
        chk("R13 stopped", 32'(burst_act), 32'd0);
        // R10 abort by new command
        send(C_RD, col_addr(11'h010), 2'd1);
        for (int k = 0; k < 3; k++) begin
            chk("R10 first", 32'(col_out), 32'(11'h010 + 11'(k)));
            @(negedge clk);
        end
        burst("R10 restart", C_RD, 8, 0, 11'h033, 2'd2);
        // R11 clock enable hold
        mrs(3'b010, 0, 3'b010, 0);
        send(C_RD, col_addr(11'd8), 2'd0);
        chk("R11 beat0", 32'(col_out), 32'd8);
        cke = 1'b0;
        {cs_n, ras_n, cas_n, we_n} = C_RD;
        addr = col_addr(11'h100);
        @(negedge clk);
        chk("R11 hold col", 32'(col_out), 32'd8);
        chk("R11 hold act", 32'(burst_act), 32'd1);
        @(negedge clk);
        chk("R11 hold col 2", 32'(col_out), 32'd8);
        cke = 1'b1;
        {cs_n, ras_n, cas_n, we_n} = C_NOP;
        for (int k = 1; k < 4; k++) begin
            @(negedge clk);
            chk("R11 resume", 32'(col_out), 32'(8 + k));
        end
        @(negedge clk);
        chk("R11 end", 32'(burst_act), 32'd0);
        // R12 mode load blocked during burst
        mrs(3'b011, 0, 3'b010, 0);
        send(C_RD, col_addr(11'd0), 2'd0);
        mrs(3'b001, 1, 3'b011, 0);
        chk("R12 cas_lat kept", 32'(cas_lat), 32'd2);
        for (int g = 0; g < 20 && burst_act; g++) @(negedge clk);
        burst("R12 length kept", C_RD, 8, 0, 11'd0, 2'd0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule